// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block runs one NAND flash operation at a time from a short program held in a register. Software fills an opcode register with up to eight 4-bit slots, a register of four command bytes, a block number, a page index with column and spare-area select, a byte count and a mode word. A write to the start register, carrying a bank number, launches the program. The engine then steps through the slots from slot 0 upward and drives an 8-bit flash pin interface: command latch, address latch, write and read strobes, one active-low chip enable per bank, and the ready/busy input. Data moves between the flash and an internal byte buffer that software reaches through a pointer and a data window.

The host port is a plain register port with a combinational read. The offsets are: 0 opcode slots (slot n in bits 4n+3:4n), 1 command bytes (command k in bits 8k+7:8k), 2 block number, 3 column in bits 15:0 with page index in bits 21:16 and spare select in bit 31, 4 byte count, 5 data word, 6 mode (bit 0 large page, bits 2:1 extra row cycles, bits 7:4 wait limit; reset value 0xF1), 7 status, 8 start, 9 buffer pointer, 10 buffer data (write stores and advances, a read strobe advances). With default parameters a large page is 256 data bytes plus 8 spare, a small page is 64 plus 2, and the buffer holds 1024 bytes in eight units of 128.

Top module: `nand_seq`

## Requirements
- R1: After reset the engine is idle, every chip enable, write strobe and read strobe is high, command and address latches are low, the status word reads 0 and the mode word reads 0xF1.
- R2: Slots run in order from slot 0; opcode 0 or any code 12 to 15 ends the program and sets done; a program that uses all eight slots sets done after slot 7. Codes: 1-4 command byte 0-3, 5 column, 6 row, 7 user address, 8 write data, 9 wait then read data, 10 wait only, 11 status byte read.
- R3: A command opcode (1-4) makes one write cycle with the command latch high carrying command byte k = code-1.
- R4: The column opcode makes two address cycles in large-page mode and one in small-page mode, low byte first.
- R5: The row opcode sends the block number joined above the page index, the index taking 6 bits in large-page mode and 5 in small-page mode, over 2 + n address cycles where n is the mode's extra-cycle field (3 counts as 2), low byte first.
- R6: The user address opcode sends bits 7:0 of the data word as one address cycle.
- R7: A byte count of 0 moves a whole page with its spare area (264 or 66 bytes); any other count moves exactly that many bytes.
- R8: Data transfers start at buffer byte unit*128 + spare offset + column, where unit is (index&1)*4 in large-page mode and index&7 in small-page mode, and the spare offset is 256 or 64 when spare select is set.
- R9: A wait opcode holds off until ready/busy is high; no read strobe occurs while it is low. If the wait lasts past (limit+1)*16 cycles, status bit 1 is set, done is not, and the remaining slots are skipped.
- R10: The status-read opcode makes one read cycle regardless of ready/busy and stores the byte in bits 7:0 of the data word, leaving bits 31:8 unchanged.
- R11: Status bits are 0 done, 1 timeout, 2 start-while-busy, 3 busy; bits 0 to 2 are sticky and cleared only by writing 1 to them.
- R12: A start while busy is ignored (the running program and its bank continue) and sets status bit 2.
- R13: While a program runs exactly the chip enable of the started bank is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Read strobe, advances the buffer pointer at offset 10 |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| nf_ce_n | output | BANKS | Per-bank chip enables, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dout | output | 8 | Byte driven to the flash |
| nf_doe | output | 1 | Output enable for nf_dout |
| nf_din | input | 8 | Byte from the flash |
| nf_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The bench targets a read that stalls on a busy flash, where a design that ignored ready/busy would strobe reads early and fill the buffer with stale bytes, and a status read made with ready/busy held low, which a wrongly gated design would hang on. It runs a full eight-slot program with count 0, a spare offset and the clamped row length, where an off-by-one in slot stepping, the default length or the row-cycle clamp would show up as a missing or extra bus cycle. A wait that never ends is combined with a second start, so a design that let the timeout also set done, ran the next slot, or let the second start retarget the bank is caught, and an unknown opcode must end the program as opcode 0 does.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int LP_DATA  = 256,
  parameter int BANKS    = 4,
  parameter int BLK_W    = 16,
  parameter int TO_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [BANKS-1:0] nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dout,
  output logic             nf_doe,
  input  logic [7:0]       nf_din,
  input  logic             nf_rb_n
);
  localparam int UNIT     = LP_DATA / 2;
  localparam int SP_DATA  = LP_DATA / 4;
  localparam int LP_FULL  = LP_DATA + LP_DATA / 32;
  localparam int SP_FULL  = SP_DATA + SP_DATA / 32;
  localparam int BUF_SZ   = UNIT * 8;
  localparam int AW       = $clog2(BUF_SZ);
  localparam int CW       = $clog2(LP_DATA) + 1;
  localparam int CNT_W    = AW + 1;
  localparam int BANK_W   = $clog2(BANKS);
  localparam int TMR_W    = 5 + TO_SHIFT;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WLO, S_WHI, S_WAIT, S_RLO, S_RHI} state_t;
  typedef enum logic [1:0] {K_CMD, K_ADR, K_DAT, K_STA} kind_t;

  logic [31:0] seq_q, cmd_q, data_q, sh_q;
  logic [BLK_W-1:0] blk_q;
  logic [CW-1:0] col_q;
  logic [5:0] pidx_q;
  logic spare_q, large_q, rdw_q;
  logic [CNT_W-1:0] cnt_q, rem_q;
  logic [1:0] al_q;
  logic [3:0] tof_q;
  logic done_q, tmo_q, berr_q;
  logic [BANK_W-1:0] bank_q;
  logic [AW-1:0] bptr_q, eptr_q;
  logic [TMR_W-1:0] tmr_q;
  logic [2:0] slot_q;
  state_t state_q;
  kind_t kind_q;
  logic [7:0] mem [BUF_SZ];

  wire busy      = state_q != S_IDLE;
  wire start_req = reg_we && reg_addr == 4'd8;
  wire st_wr     = reg_we && reg_addr == 4'd7;
  wire buf_wr    = reg_we && reg_addr == 4'd10;
  wire buf_rd    = reg_re && reg_addr == 4'd10;

  wire [3:0] cur_op = seq_q[{slot_q, 2'b00} +: 4];
  wire [1:0] csel   = 2'(cur_op - 4'd1);
  wire last_slot    = slot_q == 3'd7;
  wire rdy          = nf_rb_n && tmr_q != '0;

  logic [31:0] row_val;
  logic [CNT_W-1:0] xfer_len, col_cyc, row_cyc;
  logic [2:0] unit_idx;
  logic [AW-1:0] start_ptr;
  logic [TMR_W-1:0] to_limit;

  always_comb begin
    row_val  = large_q ? ((32'(blk_q) << 6) | 32'(pidx_q))
                       : ((32'(blk_q) << 5) | 32'(pidx_q[4:0]));
    xfer_len = (cnt_q != '0) ? cnt_q : CNT_W'(large_q ? LP_FULL : SP_FULL);
    col_cyc  = CNT_W'(large_q ? 2 : 1);
    row_cyc  = CNT_W'(2 + ((al_q == 2'd3) ? 2 : int'(al_q)));
    unit_idx = large_q ? {pidx_q[0], 2'b00} : pidx_q[2:0];
    start_ptr = AW'(int'(unit_idx) * UNIT
                    + (spare_q ? (large_q ? LP_DATA : SP_DATA) : 0)
                    + int'(col_q));
    to_limit = TMR_W'((int'(tof_q) + 1) << TO_SHIFT);
  end

  wire op_known = cur_op != 4'd0 && cur_op <= 4'd11;
  wire step     = ((state_q == S_WHI || state_q == S_RHI) && rem_q == CNT_W'(1))
               || (state_q == S_WAIT && rdy && !rdw_q);
  wire fin_ok   = (state_q == S_FETCH && !op_known) || (step && last_slot);
  wire fin_to   = state_q == S_WAIT && !rdy && tmr_q >= to_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0; cmd_q <= '0; blk_q <= '0; col_q <= '0; pidx_q <= '0;
      spare_q <= 1'b0; cnt_q <= '0; large_q <= 1'b1; al_q <= '0; tof_q <= 4'hF;
      bptr_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          4'd0: seq_q <= reg_wdata;
          4'd1: cmd_q <= reg_wdata;
          4'd2: blk_q <= reg_wdata[BLK_W-1:0];
          4'd3: begin
            col_q   <= reg_wdata[CW-1:0];
            pidx_q  <= reg_wdata[21:16];
            spare_q <= reg_wdata[31];
          end
          4'd4: cnt_q <= reg_wdata[CNT_W-1:0];
          4'd6: begin
            large_q <= reg_wdata[0];
            al_q    <= reg_wdata[2:1];
            tof_q   <= reg_wdata[7:4];
          end
          default: ;
        endcase
      end
      if (reg_we && reg_addr == 4'd9) bptr_q <= reg_wdata[AW-1:0];
      else if (buf_wr || buf_rd)      bptr_q <= bptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (state_q == S_RLO && kind_q == K_STA) data_q[7:0] <= nf_din;
    else if (reg_we && reg_addr == 4'd5) data_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (state_q == S_RLO && kind_q == K_DAT) mem[eptr_q] <= nf_din;
    else if (buf_wr && !busy) mem[bptr_q] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; tmo_q <= 1'b0; berr_q <= 1'b0;
    end else begin
      done_q <= (done_q & ~(st_wr & reg_wdata[0])) | fin_ok;
      tmo_q  <= (tmo_q  & ~(st_wr & reg_wdata[1])) | fin_to;
      berr_q <= (berr_q & ~(st_wr & reg_wdata[2])) | (start_req & busy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; kind_q <= K_CMD; slot_q <= '0; bank_q <= '0;
      eptr_q <= '0; rem_q <= '0; sh_q <= '0; tmr_q <= '0; rdw_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_req) begin
          state_q <= S_FETCH;
          slot_q  <= '0;
          bank_q  <= reg_wdata[BANK_W-1:0];
          eptr_q  <= start_ptr;
        end
        S_FETCH: begin
          tmr_q <= '0;
          case (cur_op)
            4'd1, 4'd2, 4'd3, 4'd4: begin
              kind_q <= K_CMD; sh_q <= cmd_q >> {csel, 3'b000};
              rem_q <= CNT_W'(1); state_q <= S_WLO;
            end
            4'd5: begin
              kind_q <= K_ADR; sh_q <= 32'(col_q); rem_q <= col_cyc; state_q <= S_WLO;
            end
            4'd6: begin
              kind_q <= K_ADR; sh_q <= row_val; rem_q <= row_cyc; state_q <= S_WLO;
            end
            4'd7: begin
              kind_q <= K_ADR; sh_q <= 32'(data_q[7:0]); rem_q <= CNT_W'(1); state_q <= S_WLO;
            end
            4'd8: begin
              kind_q <= K_DAT; rem_q <= xfer_len; state_q <= S_WLO;
            end
            4'd9:  begin rdw_q <= 1'b1; state_q <= S_WAIT; end
            4'd10: begin rdw_q <= 1'b0; state_q <= S_WAIT; end
            4'd11: begin
              kind_q <= K_STA; rem_q <= CNT_W'(1); state_q <= S_RLO;
            end
            default: state_q <= S_IDLE;
          endcase
        end
        S_WLO: state_q <= S_WHI;
        S_WHI: begin
          if (kind_q == K_DAT) eptr_q <= eptr_q + 1'b1;
          if (rem_q == CNT_W'(1)) begin
            if (last_slot) state_q <= S_IDLE;
            else begin slot_q <= slot_q + 1'b1; state_q <= S_FETCH; end
          end else begin
            rem_q <= rem_q - 1'b1; sh_q <= sh_q >> 8; state_q <= S_WLO;
          end
        end
        S_WAIT: begin
          if (rdy) begin
            if (rdw_q) begin
              kind_q <= K_DAT; rem_q <= xfer_len; state_q <= S_RLO;
            end else if (last_slot) state_q <= S_IDLE;
            else begin slot_q <= slot_q + 1'b1; state_q <= S_FETCH; end
          end else if (tmr_q >= to_limit) state_q <= S_IDLE;
          else tmr_q <= tmr_q + 1'b1;
        end
        S_RLO: state_q <= S_RHI;
        S_RHI: begin
          if (kind_q == K_DAT) eptr_q <= eptr_q + 1'b1;
          if (rem_q == CNT_W'(1)) begin
            if (last_slot) state_q <= S_IDLE;
            else begin slot_q <= slot_q + 1'b1; state_q <= S_FETCH; end
          end else begin
            rem_q <= rem_q - 1'b1; state_q <= S_RLO;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  wire wr_phase = state_q == S_WLO || state_q == S_WHI;
  assign nf_ce_n = busy ? ~(BANKS'(1) << bank_q) : '1;
  assign nf_cle  = wr_phase && kind_q == K_CMD;
  assign nf_ale  = wr_phase && kind_q == K_ADR;
  assign nf_we_n = state_q != S_WLO;
  assign nf_re_n = state_q != S_RLO;
  assign nf_doe  = wr_phase;
  assign nf_dout = (kind_q == K_DAT) ? mem[eptr_q] : sh_q[7:0];

  always_comb begin
    case (reg_addr)
      4'd0:  reg_rdata = seq_q;
      4'd1:  reg_rdata = cmd_q;
      4'd2:  reg_rdata = 32'(blk_q);
      4'd3:  reg_rdata = {spare_q, 9'd0, pidx_q, 16'(col_q)};
      4'd4:  reg_rdata = 32'(cnt_q);
      4'd5:  reg_rdata = data_q;
      4'd6:  reg_rdata = {24'd0, tof_q, 1'b0, al_q, large_q};
      4'd7:  reg_rdata = {28'd0, busy, berr_q, tmo_q, done_q};
      4'd9:  reg_rdata = 32'(bptr_q);
      4'd10: reg_rdata = {24'd0, mem[bptr_q]};
      default: reg_rdata = '0;
    endcase
  end

  a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  a_r13_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[3] && reg_addr == 4'd7) |-> $countones(~nf_ce_n) == 1);
  a_r13_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_we_n && nf_re_n && &nf_ce_n) |-> !nf_cle && !nf_ale);
  a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy) |=> (berr_q && $stable(bank_q)));
  a_r9_timeout_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> (!$rose(done_q) && !busy));
  a_r9_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !nf_rb_n) |=> nf_re_n);
endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0] nf_ce_n;
  logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_doe;
  logic [7:0] nf_dout, nf_din;
  logic nf_rb_n = 1'b1;

  int total = 0, bad = 0;
  int rd_idx = 0;
  bit re_was_low = 0;
  logic [9:0] expq[$];
  logic [3:0] exp_ce = 4'hF;

  always #5 clk = ~clk;

  nand_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dout(nf_dout), .nf_doe(nf_doe), .nf_din(nf_din),
    .nf_rb_n(nf_rb_n)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 13 + 5);
  endfunction

  assign nf_din = pat(rd_idx);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus-cycle reference comparison on every clock
  always @(negedge clk) begin
    if (re_was_low && nf_re_n) rd_idx++;
    re_was_low = !nf_re_n;
    if (!nf_we_n) begin
      if (expq.size() == 0)
        chk(0, "R2 unexpected write cycle", {22'd0, nf_cle, nf_ale, nf_dout}, 32'h3FF);
      else
        chk({nf_cle, nf_ale, nf_dout} == expq[0], "R3/R4/R5 write cycle",
            {22'd0, nf_cle, nf_ale, nf_dout}, {22'd0, expq[0]});
      if (expq.size() != 0) void'(expq.pop_front());
      chk(nf_ce_n == exp_ce, "R13 chip enable", {28'd0, nf_ce_n}, {28'd0, exp_ce});
    end
  end

  task automatic pcmd(input logic [7:0] b); expq.push_back({2'b10, b}); endtask
  task automatic padr(input logic [7:0] b); expq.push_back({2'b01, b}); endtask
  task automatic pdat(input logic [7:0] b); expq.push_back({2'b00, b}); endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic buf_next(output logic [7:0] b);
    @(negedge clk); reg_addr = 4'd10; reg_re = 1'b1; #1; b = reg_rdata[7:0];
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(4'd7, s);
      if (!s[3]) break;
    end
  endtask

  task automatic launch(input int bank);
    exp_ce = ~(4'(1) << bank);
    wr(4'd8, bank);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [7:0] b;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd7, s); chk(s == 0, "R1 status after reset", s, 0);
    rd(4'd6, s); chk(s == 32'hF1, "R1 mode after reset", s, 32'hF1);
    chk({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale} == 8'b1111_1100, "R1 pins after reset",
        {24'd0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 32'hFC);

    // large-page read, stalled by busy flash (R4 R5 R7 R8 R9)
    wr(4'd0, 32'h0009_2651); wr(4'd1, 32'h10D0_3000); wr(4'd2, 32'h12);
    wr(4'd3, 32'h0005_0003); wr(4'd4, 4); wr(4'd6, 32'hF3);
    pcmd(8'h00); padr(8'h03); padr(8'h00); padr(8'h85); padr(8'h04); padr(8'h00); pcmd(8'h30);
    nf_rb_n = 1'b0;
    base = rd_idx;
    launch(2);
    repeat (60) @(negedge clk);
    chk(rd_idx == base, "R9 no read while busy", rd_idx, base);
    rd(4'd7, s); chk(s == 32'h8, "R9 still waiting", s, 32'h8);
    nf_rb_n = 1'b1;
    wait_idle();
    chk(expq.size() == 0, "R2 read sequence complete", expq.size(), 0);
    rd(4'd7, s); chk(s == 32'h1, "R11 done after read", s, 32'h1);
    wr(4'd9, 515);
    for (int k = 0; k < 4; k++) begin
      buf_next(b); chk(b == pat(base + k), "R8 read data placement", b, pat(base + k));
    end
    wr(4'd7, 0); rd(4'd7, s); chk(s == 32'h1, "R11 write 0 keeps done", s, 32'h1);
    wr(4'd7, 1); rd(4'd7, s); chk(s == 32'h0, "R11 write 1 clears done", s, 0);

    // small-page erase with status (R5 R10)
    wr(4'd0, 32'h00B2_A361); wr(4'd1, 32'h00D0_7060); wr(4'd2, 3);
    wr(4'd3, 32'h001F_0000); wr(4'd5, 32'hCAFE_0000); wr(4'd6, 32'hF0);
    pcmd(8'h60); padr(8'h7F); padr(8'h00); pcmd(8'hD0); pcmd(8'h70);
    base = rd_idx;
    launch(0);
    wait_idle();
    chk(expq.size() == 0, "R5 erase sequence complete", expq.size(), 0);
    rd(4'd5, s); chk(s == {24'hCAFE00, pat(base)}, "R10 status byte stored", s, {24'hCAFE00, pat(base)});
    rd(4'd7, s); chk(s == 32'h1, "R2 erase done", s, 1);
    wr(4'd7, 7);

    // status read with flash busy (R10)
    wr(4'd0, 32'h0000_00B2);
    pcmd(8'h70);
    nf_rb_n = 1'b0;
    base = rd_idx;
    launch(1);
    wait_idle();
    rd(4'd5, s); chk(s[7:0] == pat(base), "R10 status not gated by ready", s, {24'hCAFE00, pat(base)});
    rd(4'd7, s); chk(s == 32'h1, "R10 done with flash busy", s, 1);
    nf_rb_n = 1'b1;
    wr(4'd7, 7);

    // eight-slot small-page program, spare, full length, clamped rows (R2 R5 R7 R8)
    wr(4'd9, 832);
    for (int i = 0; i < 66; i++) wr(4'd10, 32'(8'(i * 3 + 1)));
    wr(4'd0, 32'hB2A4_8653); wr(4'd1, 32'h1080_7000); wr(4'd2, 1);
    wr(4'd3, 32'h8006_0000); wr(4'd4, 0); wr(4'd6, 32'hF6);
    pcmd(8'h80); padr(8'h00); padr(8'h26); padr(8'h00); padr(8'h00); padr(8'h00);
    for (int i = 0; i < 66; i++) pdat(8'(i * 3 + 1));
    pcmd(8'h10); pcmd(8'h70);
    base = rd_idx;
    launch(3);
    wait_idle();
    chk(expq.size() == 0, "R7 full-length program emitted", expq.size(), 0);
    rd(4'd7, s); chk(s == 32'h1, "R2 done after slot 7", s, 1);
    rd(4'd5, s); chk(s[7:0] == pat(base), "R10 program status", s[7:0], pat(base));
    wr(4'd7, 7);

    // user address then read into large spare area (R6 R7 R8)
    wr(4'd0, 32'h0000_0971); wr(4'd1, 32'h0000_0090); wr(4'd5, 32'h1234_5644);
    wr(4'd3, 32'h8000_0000); wr(4'd2, 0); wr(4'd4, 5); wr(4'd6, 32'hF1);
    pcmd(8'h90); padr(8'h44);
    base = rd_idx;
    launch(3);
    wait_idle();
    chk(expq.size() == 0, "R6 user address sent", expq.size(), 0);
    chk(rd_idx - base == 5, "R7 exact count read", rd_idx - base, 5);
    wr(4'd9, 256);
    for (int k = 0; k < 5; k++) begin
      buf_next(b); chk(b == pat(base + k), "R8 spare placement", b, pat(base + k));
    end
    wr(4'd7, 7);

    // timeout with a second start while busy (R9 R12)
    wr(4'd0, 32'h0000_001A); wr(4'd1, 32'h0000_00EE); wr(4'd6, 32'h31);
    nf_rb_n = 1'b0;
    launch(1);
    repeat (10) @(negedge clk);
    wr(4'd8, 2);
    rd(4'd7, s); chk(s == 32'hC, "R12 busy start flagged", s, 32'hC);
    chk(nf_ce_n == 4'b1101, "R12 bank kept", nf_ce_n, 4'b1101);
    wait_idle();
    rd(4'd7, s); chk(s == 32'h6, "R9 timeout without done", s, 32'h6);
    chk(expq.size() == 0, "R9 aborted remaining slots", expq.size(), 0);
    nf_rb_n = 1'b1;
    wr(4'd7, 6); rd(4'd7, s); chk(s == 0, "R11 flags cleared", s, 0);

    // unknown opcode ends program (R2)
    wr(4'd0, 32'h0000_02F1); wr(4'd1, 32'h0000_00A5);
    pcmd(8'hA5);
    launch(0);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 unknown opcode ends", expq.size(), 0);
    rd(4'd7, s); chk(s == 32'h1, "R2 done on unknown opcode", s, 1);
    chk(nf_ce_n == 4'hF, "R13 deselect when idle", nf_ce_n, 4'hF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule